// File: doc/BRIEF.md
# Two-Level Significand Barrel Shifter

This block moves a 53-bit significand left or right by any amount from 0 to 63 in one combinational evaluation. It either shifts logically, filling the vacated positions with zeros, or rotates circularly. A floating-point datapath uses it for operand alignment, for postnormalization, or for a circular rotate.

The shifter is built from two cascaded multiplexer levels. The fine level moves the word by 0 to 7 positions, chosen by the three low bits of the effective amount. The coarse level moves it by a multiple of eight, from 0 to 48, chosen by the upper bits. Each input bit therefore drives at most eight candidates per level, instead of fanning out to all 53 outputs as it would in a single crossbar. In rotate mode the amount is first reduced modulo 53. In logical mode, amounts of 53 or more clear the whole word.

Top module: `sig_barrel_shift`

## Requirements
- R1: With `amt_i` = 0, `data_o` equals `data_i` for every combination of `dir_left_i` and `rotate_i`.
- R2: In logical left mode (`rotate_i`=0, `dir_left_i`=1) with 0 < n < 53, `data_o[i+n]` = `data_i[i]` and `data_o[n-1:0]` is zero.
- R3: In logical right mode (`rotate_i`=0, `dir_left_i`=0) with 0 < n < 53, `data_o[i]` = `data_i[i+n]` and the top n bits of `data_o` are zero.
- R4: In rotate left mode (`rotate_i`=1, `dir_left_i`=1), `data_o[(i+k) mod 53]` = `data_i[i]`, where k = `amt_i` mod 53.
- R5: In rotate right mode (`rotate_i`=1, `dir_left_i`=0), `data_o[i]` = `data_i[(i+k) mod 53]`, where k = `amt_i` mod 53.
- R6: In logical mode, any `amt_i` of 53 or more gives `data_o` = 0 in both directions.
- R7: In rotate mode, `amt_i` = 53 returns `data_i` unchanged, and an amount from 54 to 63 behaves exactly like that amount minus 53.
- R8: The block has no clock or state. `data_o` follows a change of any input within the same evaluation, without waiting for an edge.
- R9: In rotate mode, the number of ones in `data_o` equals the number of ones in `data_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data_i | input | 53 | Significand to move |
| amt_i | input | 6 | Shift or rotate amount, unsigned |
| dir_left_i | input | 1 | 1 = toward the MSB (left), 0 = toward the LSB (right) |
| rotate_i | input | 1 | 1 = circular rotate, 0 = logical shift with zero fill |
| data_o | output | 53 | Moved significand |

## Verification
The block holds no state, so a wrong select from either level, a bad amount reduction or a bad wrap index shows at `data_o` in the same evaluation as the input that exercises it. A fault in the fine level hits every amount that has the same low three bits. A fault in the coarse level hits a whole group of eight amounts, so a sweep of all 64 amounts in all four modes, with dense, sparse and random words, exposes each wrong path on at least one output bit. The bench also changes inputs between clock edges and checks the output at once, which catches any hidden sequential behaviour.

// File: rtl/sig_shift_pkg.sv
package sig_shift_pkg;
  localparam int SIG_W  = 53;
  localparam int FINE_W = 3;

  typedef enum logic {
    MOVE_RIGHT = 1'b0,
    MOVE_LEFT  = 1'b1
  } move_dir_e;
endpackage

// File: rtl/sig_shift_amt.sv
// Reduces the amount: modulo W for rotate, kill flag for logical overrange.
module sig_shift_amt #(
  parameter int W      = 53,
  parameter int AMT_W  = 6,
  parameter int FINE_W = 3,
  localparam int CRS_W = AMT_W - FINE_W
) (
  input  logic [AMT_W-1:0]  amt_i,
  input  logic              rotate_i,
  output logic [FINE_W-1:0] fine_o,
  output logic [CRS_W-1:0]  coarse_o,
  output logic              kill_o
);
  localparam logic [AMT_W-1:0] W_L = AMT_W'(W);

  logic             over;
  logic [AMT_W-1:0] eff;

  // amt_i < 2*W, so one conditional subtract gives the modulo
  always_comb begin
    over   = (amt_i >= W_L);
    eff    = (rotate_i && over) ? amt_i - W_L : amt_i;
    kill_o = !rotate_i && over;
  end

  assign fine_o   = eff[FINE_W-1:0];
  assign coarse_o = eff[AMT_W-1:FINE_W];
endmodule

// File: rtl/sig_shift_level.sv
// One mux level: moves data by sel_i*STEP positions, left or right, fill or wrap.
module sig_shift_level #(
  parameter int W     = 53,
  parameter int SEL_W = 3,
  parameter int STEP  = 1,
  localparam int NSEL = 2 ** SEL_W
) (
  input  logic [W-1:0]     data_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             dir_left_i,
  input  logic             rotate_i,
  output logic [W-1:0]     data_o
);
  logic [NSEL-1:0][W-1:0] cand_l;
  logic [NSEL-1:0][W-1:0] cand_r;

  for (genvar j = 0; j < NSEL; j++) begin : g_amt
    localparam int S  = j * STEP;
    localparam int SM = S % W;
    for (genvar i = 0; i < W; i++) begin : g_bit
      if (i >= S) begin : g_l_in
        assign cand_l[j][i] = data_i[i-S];
      end else begin : g_l_wrap
        assign cand_l[j][i] = rotate_i & data_i[(i - SM + W) % W];
      end
      if (i + S < W) begin : g_r_in
        assign cand_r[j][i] = data_i[i+S];
      end else begin : g_r_wrap
        assign cand_r[j][i] = rotate_i & data_i[(i + SM) % W];
      end
    end
  end

  assign data_o = dir_left_i ? cand_l[sel_i] : cand_r[sel_i];
endmodule

// File: rtl/sig_barrel_shift.sv
module sig_barrel_shift
  import sig_shift_pkg::*;
#(
  parameter int W      = SIG_W,
  parameter int FINE_W = sig_shift_pkg::FINE_W,
  localparam int AMT_W = $clog2(W + 1),
  localparam int CRS_W = AMT_W - FINE_W
) (
  input  logic [W-1:0]     data_i,
  input  logic [AMT_W-1:0] amt_i,
  input  logic             dir_left_i,
  input  logic             rotate_i,
  output logic [W-1:0]     data_o
);
  move_dir_e         dir;
  logic [FINE_W-1:0] fine_sel;
  logic [CRS_W-1:0]  coarse_sel;
  logic              kill;
  logic [W-1:0]      fine_q;
  logic [W-1:0]      coarse_q;

  assign dir = move_dir_e'(dir_left_i);

  sig_shift_amt #(.W(W), .AMT_W(AMT_W), .FINE_W(FINE_W)) u_amt (
    .amt_i    (amt_i),
    .rotate_i (rotate_i),
    .fine_o   (fine_sel),
    .coarse_o (coarse_sel),
    .kill_o   (kill)
  );

  sig_shift_level #(.W(W), .SEL_W(FINE_W), .STEP(1)) u_fine (
    .data_i     (data_i),
    .sel_i      (fine_sel),
    .dir_left_i (dir == MOVE_LEFT),
    .rotate_i   (rotate_i),
    .data_o     (fine_q)
  );

  sig_shift_level #(.W(W), .SEL_W(CRS_W), .STEP(2 ** FINE_W)) u_coarse (
    .data_i     (fine_q),
    .sel_i      (coarse_sel),
    .dir_left_i (dir == MOVE_LEFT),
    .rotate_i   (rotate_i),
    .data_o     (coarse_q)
  );

  assign data_o = kill ? '0 : coarse_q;
endmodule

// File: rtl/sig_barrel_shift_chk.sv
module sig_barrel_shift_chk #(
  parameter int W     = 53,
  parameter int AMT_W = 6
) (
  input logic [W-1:0]     data_i,
  input logic [AMT_W-1:0] amt_i,
  input logic             dir_left_i,
  input logic             rotate_i,
  input logic [W-1:0]     data_o
);
  localparam logic [AMT_W-1:0] W_L = AMT_W'(W);

  always_comb begin
    // R1
    if (amt_i == '0) begin
      zero_amt_chk: assert (data_o == data_i);
    end
    // R6
    if (!rotate_i && amt_i >= W_L) begin
      log_over_chk: assert (data_o == '0);
    end
    // R7
    if (rotate_i && amt_i == W_L) begin
      rot_full_chk: assert (data_o == data_i);
    end
    // R9
    if (rotate_i) begin
      rot_pop_chk: assert ($countones(data_o) == $countones(data_i));
    end
    // R2
    if (!rotate_i && dir_left_i && amt_i != '0) begin
      left_fill_chk: assert (data_o[0] == 1'b0);
    end
    // R3
    if (!rotate_i && !dir_left_i && amt_i != '0) begin
      right_fill_chk: assert (data_o[W-1] == 1'b0);
    end
  end
endmodule

bind sig_barrel_shift sig_barrel_shift_chk #(.W(W), .AMT_W(AMT_W)) u_chk (
  .data_i     (data_i),
  .amt_i      (amt_i),
  .dir_left_i (dir_left_i),
  .rotate_i   (rotate_i),
  .data_o     (data_o)
);

// File: tb/sim_sig_barrel_shift.sv
module sim_sig_barrel_shift;
  localparam int CLK_PERIOD = 10;
  localparam int W = 53;

  logic         clk;
  logic         rst_ni;
  logic [W-1:0] data_i;
  logic [5:0]   amt_i;
  logic         dir_left_i;
  logic         rotate_i;
  logic [W-1:0] data_o;

  int n_cmp = 0;
  int n_bad = 0;

  sig_barrel_shift u0 (
    .data_i     (data_i),
    .amt_i      (amt_i),
    .dir_left_i (dir_left_i),
    .rotate_i   (rotate_i),
    .data_o     (data_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [W-1:0] ref_move(input logic [W-1:0] d, input int a,
                                            input bit left, input bit rot);
    logic [W-1:0] r = '0;
    int k;
    if (rot) begin
      k = a % W;
      for (int i = 0; i < W; i++) begin
        if (left) r[(i + k) % W] = d[i];
        else      r[i] = d[(i + k) % W];
      end
    end else if (a < W) begin
      for (int i = 0; i < W; i++) begin
        if (left && i + a < W)  r[i + a] = d[i];
        if (!left && i + a < W) r[i] = d[i + a];
      end
    end
    return r;
  endfunction

  function automatic string req_of(input int a, input bit left, input bit rot);
    if (a == 0)            return "R1";
    if (!rot && a >= W)    return "R6";
    if (rot && a >= W)     return "R7";
    if (rot)               return left ? "R4" : "R5";
    return left ? "R2" : "R3";
  endfunction

  function automatic logic [W-1:0] rnd_word();
    return {$urandom(), $urandom()};
  endfunction

  task automatic compare(input string req, input logic [W-1:0] exp);
    n_cmp++;
    if (data_o !== exp) begin
      n_bad++;
      $display("FAIL %s amt=%0d left=%0b rot=%0b got=%h exp=%h",
               req, amt_i, dir_left_i, rotate_i, data_o, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] d, input int a, input bit left, input bit rot);
    @(posedge clk);
    #1;
    data_i = d; amt_i = 6'(a); dir_left_i = left; rotate_i = rot;
    @(negedge clk);
    compare(req_of(a, left, rot), ref_move(d, a, left, rot));
    if (rot) begin
      n_cmp++;
      if ($countones(data_o) != $countones(d)) begin
        n_bad++;
        $display("FAIL R9 popcount got=%0d exp=%0d", $countones(data_o), $countones(d));
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired got=running exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [W-1:0] pats [4];
    rst_ni = 1'b0;
    data_i = '0; amt_i = '0; dir_left_i = 1'b0; rotate_i = 1'b0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    compare("R1 idle", '0);

    // directed corners
    apply({W{1'b1}}, 52, 1'b1, 1'b0);               // R2 single bit survives
    apply({W{1'b1}}, 52, 1'b0, 1'b0);               // R3
    apply({W{1'b1}}, 53, 1'b1, 1'b0);               // R6
    apply(53'h1, 53, 1'b1, 1'b1);                   // R7 identity
    apply(53'h1, 60, 1'b1, 1'b1);                   // R7 60 acts as 7
    apply(53'h1, 1, 1'b0, 1'b1);                    // R5 LSB wraps to MSB
    apply({1'b1, 52'h0}, 1, 1'b1, 1'b1);            // R4 MSB wraps to LSB

    // R8: output follows inputs between edges
    @(negedge clk);
    data_i = 53'h1; amt_i = 6'd9; dir_left_i = 1'b1; rotate_i = 1'b0;
    #1;
    compare("R8", 53'h200);
    amt_i = 6'd17;
    #1;
    compare("R8", 53'h20000);

    // full sweep: every amount, every mode, several words (R1..R7, R9)
    pats[0] = {W{1'b1}};
    pats[1] = 53'h1;
    pats[2] = {1'b1, 52'h0};
    for (int a = 0; a < 64; a++) begin
      for (int m = 0; m < 4; m++) begin
        pats[3] = rnd_word();
        for (int p = 0; p < 4; p++) apply(pats[p], a, m[0], m[1]);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule